// File: doc/BRIEF.md
# Double-Buffered Peripheral Word Mover

This block is one DMA channel that copies 32-bit words between a peripheral port and a memory port. Software sets it up through five word-wide registers: control, status, memory pointer, memory sequence and peripheral pointer. It then starts the channel by setting the enable bit. Each word is moved as a read on the source port followed by a write on the destination port. Both ports use a plain strobe-and-ready handshake. The peripheral address stays fixed, as it would for a data FIFO. The memory address advances by four bytes per word.

The channel has two modes. In one-shot mode it moves the programmed count plus one words, raises its end-of-count flag and stops by itself. In continuous mode the programmed count covers one half of a buffer. Each half ends with its own end-of-count event and flips a ping-pong flag, and the channel runs until software clears enable. With double buffering selected, the memory address continues into the second half and returns to the base at the end of it. The base pointers are re-read at that return, so software can refill the idle half and move the buffer while the other half is still running.

Software can pace transfers with one of 31 peripheral request lines, and select code 31 or the hold bit freezes the channel. A freeze lets software read a stable remaining count.

Top module: `dma_pp_chan`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and no bus strobe is asserted.
- R2: With control bit 27 (once) set, setting control bit 31 (enable) moves the count field (control bits 15:2) plus one words. Memory addresses run from the memory pointer (register 2) upward in steps of 4, with pointer bits 1:0 forced to zero. All peripheral accesses use the peripheral pointer (register 4). The channel then stops, status bit 31 (busy) drops and control bit 31 reads back 0.
- R3: Control bit 28 (direction) selects the data path. At 0, each word is read from the peripheral port and written unchanged to the memory port. At 1, each word is read from the memory port and written unchanged to the peripheral port.
- R4: With control bit 21 (flow) set, one word starts for each cycle in which the request line chosen by control bits 20:16 is high while the channel waits. Other lines have no effect. With bit 21 clear, words move back to back.
- R5: Select code 31 in control bits 20:16 stops new words from starting while the channel stays busy, and status bit 29 (halt) reads 1. Status bits 15:2 then hold a stable value equal to the words still to move minus one. Restoring a valid code lets the transfer finish.
- R6: Control bit 29 (hold) also stops new words from starting and sets status bit 29. Clearing it resumes the transfer.
- R7: At the end of each count, status bit 30 (end-of-count) becomes 1. `irq` equals that bit ANDed with control bit 30 (interrupt enable).
- R8: Writing register 1 with bit 30 set clears the end-of-count flag. Writing register 1 with bit 30 clear leaves the flag set.
- R9: With control bit 27 clear, the count reloads at each end of count and the channel keeps running. Status bit 28 (ping-pong) starts at 0 and toggles at each end of count.
- R10: In continuous mode with register 3 bit 19 (double buffer) set, the memory address keeps advancing through the second half and returns to the base after it. With bit 19 clear, the address returns to the base after every count.
- R11: A pointer rewritten while the channel runs is used only from the next return to the base.
- R12: Clearing enable lets the word in flight complete. Busy then drops, no further requests are accepted, and the remaining count stays frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears one cycle later |
| reg_addr | input | 3 | Register word index (0 control, 1 status, 2 memory pointer, 3 memory sequence, 4 peripheral pointer) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered register read data |
| req_lines | input | 32 | Peripheral request lines; line 31 is never honoured |
| irq | output | 1 | End-of-count interrupt |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address (byte units) |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory handshake complete |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_addr | output | ADDR_W | Peripheral address |
| per_wdata | output | DATA_W | Peripheral write data |
| per_rdata | input | DATA_W | Peripheral read data, valid with per_ready |
| per_ready | input | 1 | Peripheral handshake complete |

## Verification
Assertions check several rules on every cycle. The count reloads and the ping-pong flag flips at each continuous end of count. No word starts while the select code is invalid or hold is set. A clear request removes the end-of-count flag. A stopped, disabled channel keeps its remaining count. A one-shot finish drops busy and clears enable. The address offset steps by one per word and returns to zero at a wrap. Some properties only the bench scenarios can show, because they depend on whole sequences. These are the exact address and data order on the destination port, a pointer rewrite taking effect only after the second half, and the absence of any write under frozen or disabled conditions.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;
  localparam int CNT_W  = 14;
  localparam int SEL_W  = 5;
  localparam logic [SEL_W-1:0] SEL_NONE = '1;

  localparam int CTL_EN   = 31;
  localparam int CTL_IE   = 30;
  localparam int CTL_HOLD = 29;
  localparam int CTL_DIR  = 28;
  localparam int CTL_ONCE = 27;
  localparam int CTL_FLOW = 21;
  localparam int SEL_LO   = 16;
  localparam int CNT_LO   = 2;

  localparam int STA_BUSY = 31;
  localparam int STA_EOC  = 30;
  localparam int STA_HALT = 29;
  localparam int STA_PP   = 28;

  localparam int SEQ_DB   = 19;

  typedef enum logic [2:0] {
    REG_CTL  = 3'd0,
    REG_STA  = 3'd1,
    REG_MPTR = 3'd2,
    REG_MSEQ = 3'd3,
    REG_PPTR = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_OFF, ST_WAIT, ST_RD, ST_WR
  } xfer_st_e;

  typedef struct packed {
    logic             en;
    logic             ie;
    logic             hold;
    logic             dir;
    logic             once;
    logic             flow;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cnt;
  } ctl_t;
endpackage

// File: rtl/dma_pp_regs.sv
module dma_pp_regs
  import dma_pp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output ctl_t              ctl,
  output logic [ADDR_W-1:0] mem_ptr,
  output logic [ADDR_W-1:0] per_ptr,
  output logic              db,
  output logic              eoc_clr,
  input  logic              fin,
  input  logic              busy,
  input  logic              eoc,
  input  logic              halt,
  input  logic              pp,
  input  logic [CNT_W-1:0]  remain
);
  reg_sel_e    sel_r;
  logic [31:0] rd_word;

  assign sel_r   = reg_sel_e'(reg_addr);
  assign eoc_clr = wr_en && (sel_r == REG_STA) && wr_data[STA_EOC];

  always_comb begin
    case (sel_r)
      REG_CTL:  rd_word = {ctl.en, ctl.ie, ctl.hold, ctl.dir, ctl.once, 5'b0,
                           ctl.flow, ctl.sel, ctl.cnt, 2'b00};
      REG_STA:  rd_word = {busy, eoc, halt, pp, 12'b0, remain, 2'b00};
      REG_MPTR: rd_word = 32'(mem_ptr);
      REG_MSEQ: rd_word = 32'(db) << SEQ_DB;
      REG_PPTR: rd_word = 32'(per_ptr);
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '0;
      mem_ptr <= '0;
      per_ptr <= '0;
      db      <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        case (sel_r)
          REG_CTL: begin
            ctl.en   <= wr_data[CTL_EN];
            ctl.ie   <= wr_data[CTL_IE];
            ctl.hold <= wr_data[CTL_HOLD];
            ctl.dir  <= wr_data[CTL_DIR];
            ctl.once <= wr_data[CTL_ONCE];
            ctl.flow <= wr_data[CTL_FLOW];
            ctl.sel  <= wr_data[SEL_LO +: SEL_W];
            ctl.cnt  <= wr_data[CNT_LO +: CNT_W];
          end
          REG_MPTR: mem_ptr <= {wr_data[ADDR_W-1:2], 2'b00};
          REG_MSEQ: db      <= wr_data[SEQ_DB];
          REG_PPTR: per_ptr <= {wr_data[ADDR_W-1:2], 2'b00};
          default: ;
        endcase
      end
      if (fin) ctl.en <= 1'b0;
      if (rd_en) rd_data <= rd_word;
    end
  end

  p_fin_clears_en_r2: assert property (@(posedge clk) disable iff (rst)
    fin |=> !ctl.en);
endmodule

// File: rtl/dma_pp_agen.sv
module dma_pp_agen
  import dma_pp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              wrap,
  input  logic [ADDR_W-1:0] mem_ptr,
  input  logic [ADDR_W-1:0] per_ptr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] per_addr
);
  localparam int OFF_W = CNT_W + 1;

  logic [ADDR_W-1:0] mem_base;
  logic [ADDR_W-1:0] per_base;
  logic [OFF_W-1:0]  off;

  assign mem_addr = mem_base + ADDR_W'({off, 2'b00});
  assign per_addr = per_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_base <= '0;
      per_base <= '0;
      off      <= '0;
    end else if (load || wrap) begin
      mem_base <= mem_ptr;
      per_base <= per_ptr;
      off      <= '0;
    end else if (step) begin
      off <= off + 1'b1;
    end
  end

  p_step_r10: assert property (@(posedge clk) disable iff (rst)
    (step && !wrap && !load) |=> (off == OFF_W'($past(off) + 1'b1)));
  p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (off == '0));
endmodule

// File: rtl/dma_pp_xfer.sv
module dma_pp_xfer
  import dma_pp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctl_t                   ctl,
  input  logic                   db,
  input  logic                   eoc_clr,
  input  logic [(1<<SEL_W)-1:0]  req,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  logic                   mem_ready,
  input  logic [DATA_W-1:0]      per_rdata,
  input  logic                   per_ready,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic                   per_rd,
  output logic                   per_wr,
  output logic [DATA_W-1:0]      wdata,
  output logic                   busy,
  output logic                   eoc,
  output logic                   pp,
  output logic                   halt,
  output logic [CNT_W-1:0]       remain,
  output logic                   fin,
  output logic                   load,
  output logic                   step,
  output logic                   wrap
);
  localparam int REQ_N = 1 << SEL_W;

  xfer_st_e         st;
  logic [REQ_N-1:0] req_ok;
  logic             sel_ok, flow_go, start_word;
  logic             src_ready, dst_ready, word_done, last, end_evt;
  logic [DATA_W-1:0] src_data;

  for (genvar g = 0; g < REQ_N; g++) begin : g_req
    if (g == int'(SEL_NONE)) begin : g_dead
      assign req_ok[g] = 1'b0;
    end else begin : g_live
      assign req_ok[g] = req[g];
    end
  end

  assign sel_ok     = (ctl.sel != SEL_NONE);
  assign flow_go    = !ctl.flow || req_ok[ctl.sel];
  assign start_word = (st == ST_WAIT) && ctl.en && !ctl.hold && sel_ok && flow_go;
  assign halt       = busy && (ctl.hold || !sel_ok);

  assign mem_rd    = (st == ST_RD) &&  ctl.dir;
  assign per_rd    = (st == ST_RD) && !ctl.dir;
  assign mem_wr    = (st == ST_WR) && !ctl.dir;
  assign per_wr    = (st == ST_WR) &&  ctl.dir;
  assign src_ready = ctl.dir ? mem_ready : per_ready;
  assign dst_ready = ctl.dir ? per_ready : mem_ready;
  assign src_data  = ctl.dir ? mem_rdata : per_rdata;

  assign word_done = (st == ST_WR) && dst_ready;
  assign last      = (remain == '0);
  assign end_evt   = word_done && last;
  assign load      = (st == ST_OFF) && ctl.en;
  assign step      = word_done;
  assign wrap      = end_evt && !ctl.once && (!db || pp);
  assign fin       = end_evt && ctl.once;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_OFF;
      busy   <= 1'b0;
      eoc    <= 1'b0;
      pp     <= 1'b0;
      remain <= '0;
      wdata  <= '0;
    end else begin
      if (end_evt)      eoc <= 1'b1;
      else if (eoc_clr) eoc <= 1'b0;
      case (st)
        ST_OFF: if (ctl.en) begin
          remain <= ctl.cnt;
          pp     <= 1'b0;
          busy   <= 1'b1;
          st     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!ctl.en) begin
            busy <= 1'b0;
            st   <= ST_OFF;
          end else if (start_word) begin
            st <= ST_RD;
          end
        end
        ST_RD: if (src_ready) begin
          wdata <= src_data;
          st    <= ST_WR;
        end
        ST_WR: if (dst_ready) begin
          if (!last) begin
            remain <= remain - 1'b1;
            st     <= ST_WAIT;
          end else if (ctl.once) begin
            busy <= 1'b0;
            st   <= ST_OFF;
          end else begin
            remain <= ctl.cnt;
            pp     <= ~pp;
            st     <= ST_WAIT;
          end
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  p_reload_r9: assert property (@(posedge clk) disable iff (rst)
    (end_evt && !ctl.once) |=> (remain == $past(ctl.cnt)));
  p_pp_flip_r9: assert property (@(posedge clk) disable iff (rst)
    (end_evt && !ctl.once) |=> (pp != $past(pp)));
  p_bad_sel_r5: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_WAIT) && !sel_ok) |=> (st != ST_RD));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_WAIT) && ctl.hold) |=> (st != ST_RD));
  p_eoc_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (eoc_clr && !end_evt) |=> !eoc);
  p_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ctl.en) |=> $stable(remain));
  p_oneshot_stop_r2: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy);
endmodule

// File: rtl/dma_pp_chan.sv
module dma_pp_chan
  import dma_pp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [2:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [(1<<SEL_W)-1:0] req_lines,
  output logic                  irq,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  input  logic                  mem_ready,
  output logic                  per_rd,
  output logic                  per_wr,
  output logic [ADDR_W-1:0]     per_addr,
  output logic [DATA_W-1:0]     per_wdata,
  input  logic [DATA_W-1:0]     per_rdata,
  input  logic                  per_ready
);
  ctl_t              ctl;
  logic [ADDR_W-1:0] mem_ptr, per_ptr;
  logic              db, eoc_clr, fin, busy, eoc, halt, pp;
  logic [CNT_W-1:0]  remain;
  logic              load, step, wrap;
  logic [DATA_W-1:0] wdata;

  dma_pp_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .reg_addr(reg_addr),
    .wr_data(reg_wdata), .rd_data(reg_rdata), .ctl(ctl), .mem_ptr(mem_ptr),
    .per_ptr(per_ptr), .db(db), .eoc_clr(eoc_clr), .fin(fin), .busy(busy),
    .eoc(eoc), .halt(halt), .pp(pp), .remain(remain)
  );

  dma_pp_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst(rst), .ctl(ctl), .db(db), .eoc_clr(eoc_clr), .req(req_lines),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .per_rdata(per_rdata),
    .per_ready(per_ready), .mem_rd(mem_rd), .mem_wr(mem_wr), .per_rd(per_rd),
    .per_wr(per_wr), .wdata(wdata), .busy(busy), .eoc(eoc), .pp(pp), .halt(halt),
    .remain(remain), .fin(fin), .load(load), .step(step), .wrap(wrap)
  );

  dma_pp_agen #(.ADDR_W(ADDR_W)) u_agen (
    .clk(clk), .rst(rst), .load(load), .step(step), .wrap(wrap),
    .mem_ptr(mem_ptr), .per_ptr(per_ptr), .mem_addr(mem_addr), .per_addr(per_addr)
  );

  assign mem_wdata = wdata;
  assign per_wdata = wdata;
  assign irq       = eoc && ctl.ie;

  p_irq_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> eoc);
endmodule

// File: tb/tb_dma_pp_chan.sv
`timescale 1ns/1ps
module tb_dma_pp_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [31:0] req_lines = '0;
  logic        irq;
  logic        mem_rd, mem_wr, per_rd, per_wr;
  logic [31:0] mem_addr, mem_wdata, per_addr, per_wdata, mem_rdata, per_rdata;
  logic        mem_ready = 1'b1, per_ready = 1'b1;

  always #2 clk = ~clk;

  dma_pp_chan dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_lines(req_lines), .irq(irq),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .per_rd(per_rd), .per_wr(per_wr),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata),
    .per_ready(per_ready)
  );

  int compared = 0, mismatched = 0, writes_seen = 0, cyc = 0;
  int exp_pseq = 0;
  logic [31:0] per_seq = '0;
  logic [64:0] exp_q[$];
  string       tag_q[$];

  assign mem_rdata = mem_addr ^ 32'h5A5A_0000;
  assign per_rdata = 32'hC0DE_0000 + per_seq;
  always @(posedge clk) if (per_rd && per_ready) per_seq <= per_seq + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic push(input string tag, input logic to_mem, input logic [31:0] a,
                      input logic [31:0] d);
    exp_q.push_back({to_mem, a, d});
    tag_q.push_back(tag);
  endtask
  task automatic push_p2m(input string tag, input logic [31:0] a);
    push(tag, 1'b1, a, 32'hC0DE_0000 + exp_pseq);
    exp_pseq++;
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    cyc++;
    if (!rst && (mem_wr || per_wr)) begin
      logic [64:0] e;
      string t;
      writes_seen++;
      if (exp_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R12 unexpected write actual=%h expected=none",
                 mem_wr ? mem_addr : per_addr);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " port"}, {31'b0, mem_wr}, {31'b0, e[64]});
        chk({t, " addr"}, mem_wr ? mem_addr : per_addr, e[63:32]);
        chk({t, " data"}, mem_wr ? mem_wdata : per_wdata, e[31:0]);
      end
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask
  function automatic logic [31:0] cw(input logic en, ie, hold, dir, once, flow,
                                     input logic [4:0] sel, input logic [13:0] cnt);
    return {en, ie, hold, dir, once, 5'b0, flow, sel, cnt, 2'b00};
  endfunction
  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rreg(3'd1, s);
      if (!s[31]) break;
    end
  endtask
  task automatic pulse(input int line);
    repeat (2) @(negedge clk);
    req_lines[line] = 1'b1;
    @(negedge clk);
    req_lines[line] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(negedge clk) if (cyc == 150000) begin
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
    finish_run();
  end

  initial begin
    logic [31:0] s, s2;
    int ws;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 strobes", {28'b0, mem_rd, mem_wr, per_rd, per_wr}, 32'd0);
    rreg(3'd1, s); chk("R1 status", s, 32'd0);
    rreg(3'd0, s); chk("R1 control", s, 32'd0);

    // R2/R7/R8 one-shot, peripheral to memory
    wreg(3'd2, 32'h0000_1000);
    wreg(3'd4, 32'h0000_0040);
    for (int i = 0; i < 4; i++) push_p2m("R2", 32'h1000 + 4*i);
    wreg(3'd0, cw(1,1,0,0,1,0,5'd0,14'd3));
    wait_idle();
    chk("R2 queue drained", exp_q.size(), 0);
    rreg(3'd0, s); chk("R2 enable cleared", {31'b0, s[31]}, 32'd0);
    rreg(3'd1, s); chk("R7 eoc set", {31'b0, s[30]}, 32'd1);
    chk("R2 remain zero", {18'b0, s[15:2]}, 32'd0);
    chk("R7 irq high", {31'b0, irq}, 32'd1);
    wreg(3'd1, 32'h0);
    rreg(3'd1, s); chk("R8 no clear on zero", {31'b0, s[30]}, 32'd1);
    wreg(3'd1, 32'h4000_0000);
    rreg(3'd1, s); chk("R8 cleared", {31'b0, s[30]}, 32'd0);
    chk("R7 irq low", {31'b0, irq}, 32'd0);

    // R3 memory to peripheral, unaligned pointer
    wreg(3'd2, 32'h0000_2002);
    wreg(3'd4, 32'h0000_0080);
    for (int i = 0; i < 3; i++) push("R3", 1'b0, 32'h80, (32'h2000 + 4*i) ^ 32'h5A5A_0000);
    wreg(3'd0, cw(1,0,0,1,1,0,5'd0,14'd2));
    wait_idle();
    chk("R3 queue drained", exp_q.size(), 0);
    chk("R7 irq masked", {31'b0, irq}, 32'd0);
    wreg(3'd1, 32'h4000_0000);

    // R4 flow control paced by line 5
    wreg(3'd2, 32'h0000_1800);
    wreg(3'd0, cw(1,0,0,0,1,1,5'd5,14'd2));
    ws = writes_seen;
    repeat (20) @(negedge clk);
    chk("R4 no request no word", writes_seen - ws, 0);
    rreg(3'd1, s); chk("R4 remain full", {18'b0, s[15:2]}, 32'd2);
    push_p2m("R4", 32'h1800);
    pulse(5);
    chk("R4 one word per request", writes_seen - ws, 1);
    pulse(4);
    chk("R4 other line ignored", writes_seen - ws, 1);
    push_p2m("R4", 32'h1804); pulse(5);
    push_p2m("R4", 32'h1808); pulse(5);
    wait_idle();
    chk("R4 done", writes_seen - ws, 3);
    wreg(3'd1, 32'h4000_0000);

    // R5 invalid select freezes
    wreg(3'd2, 32'h0000_7000);
    for (int i = 0; i < 40; i++) push_p2m("R5", 32'h7000 + 4*i);
    ws = writes_seen;
    wreg(3'd0, cw(1,0,0,0,1,0,5'd0,14'd39));
    repeat (12) @(negedge clk);
    wreg(3'd0, cw(1,0,0,0,1,0,5'd31,14'd39));
    repeat (4) @(negedge clk);
    rreg(3'd1, s);
    chk("R5 busy", {31'b0, s[31]}, 32'd1);
    chk("R5 halt", {31'b0, s[29]}, 32'd1);
    chk("R5 remain matches", {18'b0, s[15:2]}, 32'(39 - (writes_seen - ws)));
    repeat (20) @(negedge clk);
    rreg(3'd1, s2);
    chk("R5 remain stable", {18'b0, s2[15:2]}, {18'b0, s[15:2]});
    wreg(3'd0, cw(1,0,0,0,1,0,5'd0,14'd39));
    wait_idle();
    chk("R5 resumed all", writes_seen - ws, 40);
    wreg(3'd1, 32'h4000_0000);

    // R6 hold bit
    wreg(3'd2, 32'h0000_7800);
    for (int i = 0; i < 30; i++) push_p2m("R6", 32'h7800 + 4*i);
    ws = writes_seen;
    wreg(3'd0, cw(1,0,0,0,1,0,5'd0,14'd29));
    repeat (10) @(negedge clk);
    wreg(3'd0, cw(1,0,1,0,1,0,5'd0,14'd29));
    repeat (4) @(negedge clk);
    s2 = writes_seen;
    rreg(3'd1, s); chk("R6 halt", {31'b0, s[29]}, 32'd1);
    repeat (20) @(negedge clk);
    chk("R6 no words", writes_seen, s2);
    wreg(3'd0, cw(1,0,0,0,1,0,5'd0,14'd29));
    wait_idle();
    chk("R6 resumed all", writes_seen - ws, 30);
    wreg(3'd1, 32'h4000_0000);

    // R9/R10/R11 continuous, double buffered, paced by line 2
    wreg(3'd3, 32'h0008_0000);
    wreg(3'd2, 32'h0000_3000);
    wreg(3'd0, cw(1,0,0,0,0,1,5'd2,14'd1));
    push_p2m("R10", 32'h3000); pulse(2);
    push_p2m("R10", 32'h3004); pulse(2);
    rreg(3'd1, s);
    chk("R9 pp after first half", {31'b0, s[28]}, 32'd1);
    chk("R9 still busy", {31'b0, s[31]}, 32'd1);
    chk("R9 count reloaded", {18'b0, s[15:2]}, 32'd1);
    chk("R7 eoc first half", {31'b0, s[30]}, 32'd1);
    wreg(3'd1, 32'h4000_0000);
    wreg(3'd2, 32'h0000_5000);
    push_p2m("R11", 32'h3008); pulse(2);
    push_p2m("R11", 32'h300C); pulse(2);
    rreg(3'd1, s);
    chk("R9 pp after second half", {31'b0, s[28]}, 32'd0);
    chk("R7 eoc second half", {31'b0, s[30]}, 32'd1);
    wreg(3'd1, 32'h4000_0000);
    push_p2m("R11", 32'h5000); pulse(2);
    push_p2m("R11", 32'h5004); pulse(2);
    rreg(3'd1, s); chk("R9 pp toggles again", {31'b0, s[28]}, 32'd1);
    wreg(3'd0, cw(0,0,0,0,0,1,5'd2,14'd1));
    repeat (3) @(negedge clk);
    rreg(3'd1, s);
    chk("R12 busy dropped", {31'b0, s[31]}, 32'd0);
    chk("R12 remain frozen", {18'b0, s[15:2]}, 32'd1);
    wreg(3'd1, 32'h4000_0000);

    // R10 continuous without double buffering
    wreg(3'd3, 32'h0);
    wreg(3'd2, 32'h0000_6000);
    wreg(3'd0, cw(1,0,0,0,0,1,5'd7,14'd1));
    for (int h = 0; h < 2; h++) begin
      push_p2m("R10 single", 32'h6000); pulse(7);
      push_p2m("R10 single", 32'h6004); pulse(7);
    end
    rreg(3'd1, s); chk("R9 pp after two", {31'b0, s[28]}, 32'd0);
    wreg(3'd0, cw(0,0,0,0,0,1,5'd7,14'd1));
    repeat (3) @(negedge clk);
    wreg(3'd1, 32'h4000_0000);

    // R12 abort mid one-shot
    wreg(3'd2, 32'h0000_9000);
    wreg(3'd0, cw(1,0,0,0,1,1,5'd3,14'd9));
    for (int i = 0; i < 3; i++) begin push_p2m("R12", 32'h9000 + 4*i); pulse(3); end
    rreg(3'd1, s); chk("R12 remain before stop", {18'b0, s[15:2]}, 32'd6);
    wreg(3'd0, cw(0,0,0,0,1,1,5'd3,14'd9));
    repeat (3) @(negedge clk);
    ws = writes_seen;
    pulse(3); pulse(3);
    chk("R12 no words after stop", writes_seen - ws, 0);
    rreg(3'd1, s);
    chk("R12 idle", {31'b0, s[31]}, 32'd0);
    chk("R12 remain kept", {18'b0, s[15:2]}, 32'd6);
    chk("R12 scoreboard empty", exp_q.size(), 0);

    finish_run();
  end
endmodule